// File: doc/BRIEF.md
# Multi-mode 16-bit counter/timer

This block is a single 16-bit down-counter for a serial controller. One mode input chooses what it does. In character-count mode it counts received characters. In delay mode it times a single delay and then halts. In timer mode it runs without end and makes either a square wave or a one-tick pulse. In time-out mode it watches the gap between received characters.

Counting advances only when its enable input is high. In character-count mode that enable is the received-character strobe. In the other modes it is a clock-enable tick from whatever clock source the system selects. When the counter reaches its terminal count it sets a sticky interrupt flag, and software clears that flag with a one-cycle clear pulse. The current count can be read at any time. Software programs the preload value and the mode, then issues start and stop pulses.

Top module: `ctr_timer`

## Requirements
- R1: After reset, count_o is 0, wave_o is 0, irq_o is 0, and the counter is stopped. While it is stopped, ticks and characters do not change count_o.
- R2: An accepted start_i loads preload_i into the count and runs the counter. stop_i stops the counter, keeps count_o frozen and drives wave_o to 0. When start_i and stop_i are high in the same cycle, stop_i wins.
- R3: In delay mode (mode_i=1) and in timer mode (mode_i=2), a running count drops by one only in cycles where tick_i is high.
- R4: A terminal count happens when a decrement is due while the count is 1 or 0. In delay mode the terminal count leaves count_o at 0 and stops the counter. A later start_i is then ignored until a stop_i has been given.
- R5: In timer mode with pulse_sel_i=0, a start drives wave_o high. Each terminal count inverts wave_o and reloads preload_i, so each half period lasts preload_i ticks.
- R6: In timer mode with pulse_sel_i=1, each terminal count reloads preload_i and drives wave_o high. wave_o falls at the next tick that is not itself a terminal count.
- R7: In character-count mode (mode_i=0), the count drops only on rx_char_i. At the terminal count it reloads preload_i.
- R8: In time-out mode (mode_i=3), counting is disarmed after start. Every rx_char_i reloads preload_i and arms the counter, and an armed counter drops on ticks. If preload_i ticks pass with no character, the terminal count leaves count_o at 0 and disarms the counter until the next character.
- R9: irq_o goes high in the cycle after any terminal count and stays high until irq_clr_i is seen. When a terminal count and irq_clr_i fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| tick_i | input | 1 | clock-enable from the selected time base |
| rx_char_i | input | 1 | one-cycle strobe per received character |
| start_i | input | 1 | start command |
| stop_i | input | 1 | stop command |
| mode_i | input | 2 | 0 char count, 1 delay, 2 timer, 3 time-out |
| pulse_sel_i | input | 1 | timer output: 0 square wave, 1 pulse |
| preload_i | input | 16 | preload value |
| irq_clr_i | input | 1 | clears the interrupt flag |
| wave_o | output | 1 | square-wave or pulse output |
| irq_o | output | 1 | sticky terminal-count interrupt |
| count_o | output | 16 | current count |

## Verification
Two collisions matter most. The first is a terminal count in the same cycle as an interrupt clear. The bench provokes it by holding irq_clr_i high throughout a timer run with a preload of 1, so a terminal count arrives on every tick, and it expects irq_o to stay high. The second is a received character in the same cycle as an expiring tick in time-out mode. There the reload must win, and the bench expects count_o to equal the preload with no interrupt. A behavioural model in the bench settles both cases and is compared against the design on every clock, through directed phases and a long phase of random stimulus.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    M_CHAR  = 2'd0,
    M_DELAY = 2'd1,
    M_TIMER = 2'd2,
    M_TOUT  = 2'd3
  } ctr_mode_e;
endpackage

// File: rtl/ctr_count.sv
module ctr_count
  import ctr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         rx_char_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  ctr_mode_e    mode_i,
  input  logic [W-1:0] preload_i,
  output logic [W-1:0] count_o,
  output logic         tc_o,
  output logic         load_o
);
  logic [W-1:0] count_q;
  logic running_q, halted_q, armed_q;
  logic dec, load, rld_char, step, tc;

  always_comb begin
    load     = start_i && !stop_i && !halted_q;
    rld_char = running_q && !stop_i && !load && mode_i == M_TOUT && rx_char_i;
    unique case (mode_i)
      M_CHAR:  dec = rx_char_i;
      M_TOUT:  dec = armed_q && tick_i;
      default: dec = tick_i;
    endcase
    step = running_q && !stop_i && !load && !rld_char && dec;
    tc   = step && (count_q <= W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      running_q <= 1'b0;
      halted_q  <= 1'b0;
      armed_q   <= 1'b0;
    end else if (stop_i) begin
      running_q <= 1'b0;
      halted_q  <= 1'b0;
      armed_q   <= 1'b0;
    end else if (load) begin
      running_q <= 1'b1;
      count_q   <= preload_i;
      armed_q   <= 1'b0;
    end else if (rld_char) begin
      count_q <= preload_i;
      armed_q <= 1'b1;
    end else if (tc) begin
      unique case (mode_i)
        M_DELAY: begin
          count_q   <= '0;
          running_q <= 1'b0;
          halted_q  <= 1'b1;
        end
        M_TOUT: begin
          count_q <= '0;
          armed_q <= 1'b0;
        end
        default: count_q <= preload_i;
      endcase
    end else if (step) begin
      count_q <= count_q - W'(1);
    end
  end

  assign count_o = count_q;
  assign tc_o    = tc;
  assign load_o  = load;

  a_r2_stop_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !running_q && $stable(count_q));
  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && !tick_i && !stop_i && !load && (mode_i == M_DELAY || mode_i == M_TIMER))
    |=> $stable(count_q));
  a_r4_delay_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc && mode_i == M_DELAY) |=> (!running_q && count_q == '0));
  a_r4_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !stop_i) |=> !running_q);
  a_r8_char_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rld_char |=> (armed_q && count_q == $past(preload_i)));
endmodule

// File: rtl/ctr_out.sv
module ctr_out
  import ctr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      stop_i,
  input  logic      load_i,
  input  logic      tc_i,
  input  ctr_mode_e mode_i,
  input  logic      pulse_sel_i,
  input  logic      irq_clr_i,
  output logic      wave_o,
  output logic      irq_o
);
  logic wave_q, irq_q, timer_m;

  assign timer_m = (mode_i == M_TIMER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
    end else if (stop_i) begin
      wave_q <= 1'b0;
    end else if (load_i) begin
      wave_q <= timer_m && !pulse_sel_i;
    end else if (tc_i && timer_m) begin
      wave_q <= pulse_sel_i ? 1'b1 : !wave_q;
    end else if (timer_m && pulse_sel_i && tick_i && wave_q) begin
      wave_q <= 1'b0;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (tc_i)      irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign wave_o = wave_q;
  assign irq_o  = irq_q;

  a_r9_irq_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_i |=> irq_q);
  a_r9_irq_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && irq_clr_i && !tc_i) |=> !irq_q);
  a_r5_square_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && timer_m && !pulse_sel_i && !stop_i && !load_i) |=> (wave_q != $past(wave_q)));
  a_r6_pulse_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timer_m && pulse_sel_i && wave_q && tick_i && !tc_i && !stop_i && !load_i) |=> !wave_q);
endmodule

// File: rtl/ctr_timer.sv
module ctr_timer
  import ctr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         rx_char_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic [1:0]   mode_i,
  input  logic         pulse_sel_i,
  input  logic [W-1:0] preload_i,
  input  logic         irq_clr_i,
  output logic         wave_o,
  output logic         irq_o,
  output logic [W-1:0] count_o
);
  ctr_mode_e mode;
  logic tc, load;

  assign mode = ctr_mode_e'(mode_i);

  ctr_count #(.W(W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_char_i (rx_char_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .mode_i    (mode),
    .preload_i (preload_i),
    .count_o   (count_o),
    .tc_o      (tc),
    .load_o    (load)
  );

  ctr_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .stop_i      (stop_i),
    .load_i      (load),
    .tc_i        (tc),
    .mode_i      (mode),
    .pulse_sel_i (pulse_sel_i),
    .irq_clr_i   (irq_clr_i),
    .wave_o      (wave_o),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/sim_ctr_timer.sv
`timescale 1ns/1ps
module sim_ctr_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, rx = 0, start = 0, stop = 0, psel = 0, clr = 0;
  logic [1:0] mode = 0;
  logic [15:0] pre = 0;
  logic wave, irq;
  logic [15:0] cnt;

  int total = 0, bad = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  int m_cnt = 0, m_run = 0, m_halt = 0, m_arm = 0, m_wave = 0, m_irq = 0;

  always #10 clk = ~clk;

  ctr_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_char_i(rx),
    .start_i(start), .stop_i(stop), .mode_i(mode), .pulse_sel_i(psel),
    .preload_i(pre), .irq_clr_i(clr), .wave_o(wave), .irq_o(irq), .count_o(cnt)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      bit t;
      bit due;
      t = 0;
      if (stop) begin
        m_run = 0; m_halt = 0; m_arm = 0; m_wave = 0;
      end else if (start && !m_halt) begin
        m_run = 1; m_cnt = pre; m_arm = 0;
        m_wave = (mode == 2 && !psel) ? 1 : 0;
      end else begin
        if (m_run) begin
          if (mode == 3 && rx) begin
            m_cnt = pre; m_arm = 1;
          end else begin
            if (mode == 0) due = rx;
            else if (mode == 3) due = m_arm && tick;
            else due = tick;
            if (due) begin
              if (m_cnt <= 1) begin
                t = 1;
                if (mode == 1) begin m_cnt = 0; m_run = 0; m_halt = 1; end
                else if (mode == 3) begin m_cnt = 0; m_arm = 0; end
                else m_cnt = pre;
              end else m_cnt = m_cnt - 1;
            end
          end
        end
        if (t && mode == 2) m_wave = psel ? 1 : !m_wave;
        else if (mode == 2 && psel && tick && m_wave) m_wave = 0;
      end
      if (t) m_irq = 1;
      else if (clr) m_irq = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (cnt !== 16'(m_cnt) || wave !== 1'(m_wave) || irq !== 1'(m_irq)) begin
        bad++;
        $display("FAIL %s: count=%0d wave=%0b irq=%0b expected count=%0d wave=%0d irq=%0d",
                 req, cnt, wave, irq, m_cnt, m_wave, m_irq);
      end
    end
  end

  task automatic chk(input string r, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit rc, input bit st, input bit sp, input bit cl);
    tick = tk; rx = rc; start = st; stop = sp; clr = cl;
    @(negedge clk);
    tick = 0; rx = 0; start = 0; stop = 0; clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cnt == 0 && wave == 0 && irq == 0, cnt, 0);
    rst_n = 1;
    @(negedge clk);
    req = "R1";
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0);
    chk("R1", cnt == 0, cnt, 0);

    // R3 / R4 delay mode
    req = "R3"; mode = 1; pre = 5;
    cyc(0, 0, 1, 0, 0);
    chk("R2", cnt == 5, cnt, 5);
    idle(4);
    chk("R3", cnt == 5, cnt, 5);
    for (int i = 0; i < 5; i++) begin cyc(1, 0, 0, 0, 0); idle(2); end
    req = "R4";
    chk("R4", cnt == 0 && irq == 1, cnt, 0);
    pre = 9;
    cyc(0, 0, 1, 0, 0);
    chk("R4", cnt == 0, cnt, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R9", irq == 0, irq, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R4", cnt == 9, cnt, 9);

    // R2 stop beats start
    req = "R2";
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 0);
    chk("R2", cnt == 8, cnt, 8);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R2", cnt == 8, cnt, 8);

    // R5 square wave
    req = "R5"; mode = 2; psel = 0; pre = 3;
    cyc(0, 0, 1, 0, 0);
    chk("R5", wave == 1, wave, 1);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0);
    chk("R5", wave == 0 && cnt == 3, wave, 0);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, i % 5 == 0);
    cyc(0, 0, 0, 1, 0);
    chk("R2", wave == 0, wave, 0);

    // R6 pulse
    req = "R6"; psel = 1; pre = 4;
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 30; i++) cyc(i % 2 == 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);

    // R9 set beats clear: terminal count on every tick with clear held
    req = "R9"; psel = 0; pre = 1;
    cyc(0, 0, 1, 0, 1);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 1);
    chk("R9", irq == 1, irq, 1);
    cyc(0, 0, 0, 1, 1);
    chk("R9", irq == 0, irq, 0);

    // R7 char count
    req = "R7"; mode = 0; pre = 3;
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
    chk("R7", cnt == 3, cnt, 3);
    for (int i = 0; i < 3; i++) begin cyc(0, 1, 0, 0, 0); idle(1); end
    chk("R7", cnt == 3 && irq == 1, cnt, 3);
    cyc(0, 0, 0, 1, 1);

    // R8 time-out
    req = "R8"; mode = 3; pre = 6;
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 10; i++) cyc(1, 0, 0, 0, 0);
    chk("R8", cnt == 6 && irq == 0, cnt, 6);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    chk("R8", cnt == 6 && irq == 0, cnt, 6);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
    chk("R8", cnt == 0 && irq == 1, cnt, 0);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    chk("R8", cnt == 0, cnt, 0);
    cyc(0, 0, 0, 1, 1);

    // random phase, mode changes only together with stop
    for (int seg = 0; seg < 40; seg++) begin
      req = (seg % 4 == 0) ? "R7" : (seg % 4 == 1) ? "R4" : (seg % 4 == 2) ? "R5" : "R8";
      mode = 2'(seg % 4);
      psel = 1'($urandom_range(0, 1));
      pre = 16'($urandom_range(0, 7));
      cyc(0, 0, 0, 1, 0);
      for (int i = 0; i < 150; i++)
        cyc($urandom_range(0, 2) != 0, $urandom_range(0, 9) == 0,
            $urandom_range(0, 40) == 0, $urandom_range(0, 80) == 0,
            $urandom_range(0, 6) == 0);
    end
    finish_run();
  end
endmodule